// File: doc/BRIEF.md
# H-Bridge PWM Gate Sequencer

This block produces the four gate-enable signals for one full H-bridge: a high-side and a low-side switch in each of two legs. A 5-bit duty code and a rate select set a fixed-frequency PWM. A direction bit picks which diagonal conducts. In the on window the selected high side and the opposite low side are on. In the off window the motor current recirculates through both low sides, so the switching leg runs synchronous rectification. The dead time separates every hand-over between the two switches of one leg.

Duty, rate and direction are sampled only at period boundaries. A reversal is preceded by a full dead-time interval with every gate off. An overcurrent comparator input, a global fault input (supply out of range, overtemperature, watchdog loss) or a low enable turns every gate off in the same cycle. An overcurrent event is also held in a status flag. That flag keeps the bridge off until a clear strobe arrives while the comparator is low. Timing counts come from the clock rate parameter: the period is 32 steps, the fast rate is nominally 20 kHz, the slow rate is half of that, and the dead time is nominally 3 µs.

Top module: `hbridge_pwm_seq`

## Requirements
- R1: In reset, and in any cycle where `en_i` is low, all four gate outputs are 0. `oc_latched_o` is 0 after reset.
- R2: Once enabled with no fault, the bridge spends DEAD cycles with all gates off and then starts a period. A period lasts 32*STEP cycles. STEP is STEP_FAST when `freq_sel_i`=0 and 2*STEP_FAST when `freq_sel_i`=1.
- R3: With `dir_i`=0 (forward), `hs2_o` is 0 and `ls2_o` is 1 for the whole period, and leg 1 switches. With `dir_i`=1 the roles of the legs swap: `hs1_o`=0, `ls1_o`=1, and leg 2 switches.
- R4: In the switching leg, the high side is on for cycles k < (c+1)*STEP of each period, where c is the duty code. Codes below 3 are treated as 3, the 10 % minimum.
- R5: The switching leg's low side is on for cycles on+DEAD <= k < period-DEAD. The two switches of one leg are never on together, and neither turns on in the cycle after the other was on. At code 31 the high side stays on across period boundaries with no gap.
- R6: A change of duty code or rate select during a period takes effect at the start of the next period.
- R7: A direction change takes effect at the next period boundary. DEAD all-off cycles are inserted first, then a period in the new direction starts.
- R8: `oc_i` high forces all gates to 0 in the same cycle. `oc_latched_o` is 1 from the next clock edge.
- R9: `oc_latched_o` stays 1, and the gates stay off, until `oc_clr_i` is high on an edge where `oc_i` is low. Set wins over clear. After the clear, the start sequence of R2 repeats.
- R10: `fault_i` high forces all gates to 0 in the same cycle. After it drops, the start sequence of R2 repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bridge enable |
| dir_i | input | 1 | Direction: 0 forward, 1 reverse |
| duty_i | input | DUTY_W | Duty code; on time is (code+1)/32 of the period |
| freq_sel_i | input | 1 | Rate select: 0 fast, 1 half rate |
| oc_i | input | 1 | Overcurrent comparator |
| fault_i | input | 1 | Combined supply, temperature and watchdog fault |
| oc_clr_i | input | 1 | Clear strobe for the overcurrent status |
| hs1_o | output | 1 | Leg 1 high-side gate enable |
| ls1_o | output | 1 | Leg 1 low-side gate enable |
| hs2_o | output | 1 | Leg 2 high-side gate enable |
| ls2_o | output | 1 | Leg 2 low-side gate enable |
| oc_latched_o | output | 1 | Latched overcurrent status |

## Verification
The gate outputs are combinational from registered state. A period therefore starts in the cycle after the edge that ends the gap, and the bench indexes every expected gate pattern from that edge. It computes the expected pattern from the period position, the duty code and the rate.

The shutdown inputs (`oc_i`, `fault_i`, `en_i`) act in the same cycle. The bench samples shortly after driving them, before any edge. The status flag is due one edge later and is sampled at the following falling edge. Restarts after a shutdown are checked for exactly DEAD all-off cycles before cycle 0 of the new period.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_RUN} seq_st_e;
  typedef struct packed {
    logic hs1;
    logic ls1;
    logic hs2;
    logic ls2;
  } gates_t;
endpackage

// File: rtl/hbpwm_timebase.sv
module hbpwm_timebase
  import hbpwm_pkg::*;
#(
  parameter int DUTY_W    = 5,
  parameter int STEP_FAST = 78,
  parameter int DEAD_CYC  = 150,
  parameter int MIN_CODE  = 3,
  parameter int CNT_W     = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kill_i,
  input  logic              dir_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              freq_sel_i,
  output logic              run_o,
  output logic              dir_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  on_len_o,
  output logic [CNT_W-1:0]  per_len_o
);
  localparam int STEPS = 1 << DUTY_W;
  localparam int GAP_W = $clog2(DEAD_CYC + 1);
  localparam logic [CNT_W-1:0] STEP_F = CNT_W'(STEP_FAST);
  localparam logic [CNT_W-1:0] STEP_S = CNT_W'(2 * STEP_FAST);
  localparam logic [CNT_W-1:0] PER_F  = CNT_W'(STEPS * STEP_FAST);
  localparam logic [CNT_W-1:0] PER_S  = CNT_W'(2 * STEPS * STEP_FAST);
  localparam logic [DUTY_W-1:0] MIN_D = DUTY_W'(MIN_CODE);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(DEAD_CYC - 1);

  seq_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GAP_W-1:0]  gcnt_q;
  logic              dir_q, fsel_q;
  logic [DUTY_W-1:0] duty_q;

  logic [CNT_W-1:0]  step, per_len;
  logic [DUTY_W-1:0] duty_cl;
  logic              last;

  always_comb begin
    step    = fsel_q ? STEP_S : STEP_F;
    per_len = fsel_q ? PER_S : PER_F;
    duty_cl = (duty_i < MIN_D) ? MIN_D : duty_i;
    last    = (cnt_q == per_len - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      gcnt_q <= '0;
      dir_q  <= 1'b0;
      fsel_q <= 1'b0;
      duty_q <= MIN_D;
    end else if (kill_i) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_q   <= ST_GAP;
          gcnt_q <= '0;
        end
        ST_GAP: begin
          if (gcnt_q == GAP_LAST) begin
            st_q   <= ST_RUN;
            cnt_q  <= '0;
            dir_q  <= dir_i;
            duty_q <= duty_cl;
            fsel_q <= freq_sel_i;
          end else begin
            gcnt_q <= gcnt_q + GAP_W'(1);
          end
        end
        ST_RUN: begin
          if (last) begin
            if (dir_i != dir_q) begin
              // reversal: full all-off gap before the new diagonal
              st_q   <= ST_GAP;
              gcnt_q <= '0;
            end else begin
              cnt_q  <= '0;
              duty_q <= duty_cl;
              fsel_q <= freq_sel_i;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o     = (st_q == ST_RUN);
  assign dir_o     = dir_q;
  assign cnt_o     = cnt_q;
  assign per_len_o = per_len;
  assign on_len_o  = (CNT_W'(duty_q) + CNT_W'(1)) * step;
endmodule

// File: rtl/hbpwm_gate_map.sv
module hbpwm_gate_map
  import hbpwm_pkg::*;
#(
  parameter int CNT_W    = 13,
  parameter int DEAD_CYC = 150
) (
  input  logic             run_i,
  input  logic             kill_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] on_len_i,
  input  logic [CNT_W-1:0] per_len_i,
  output gates_t           gates_o
);
  localparam logic [CNT_W:0] DEAD_X = (CNT_W + 1)'(DEAD_CYC);

  logic [CNT_W:0] cnt_x, on_x, per_x;
  logic drive_hi, recirc_lo, live;

  always_comb begin
    cnt_x     = {1'b0, cnt_i};
    on_x      = {1'b0, on_len_i};
    per_x     = {1'b0, per_len_i};
    drive_hi  = cnt_x < on_x;
    recirc_lo = (cnt_x >= on_x + DEAD_X) && (cnt_x + DEAD_X < per_x);
    live      = run_i && !kill_i;
    gates_o   = '0;
    if (live) begin
      if (!dir_i) begin
        gates_o.hs1 = drive_hi;
        gates_o.ls1 = recirc_lo;
        gates_o.ls2 = 1'b1;
      end else begin
        gates_o.hs2 = drive_hi;
        gates_o.ls2 = recirc_lo;
        gates_o.ls1 = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hbpwm_oc_latch.sv
module hbpwm_oc_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  input  logic clr_i,
  output logic oc_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    oc_q_o <= 1'b0;
    else if (oc_i)  oc_q_o <= 1'b1;
    else if (clr_i) oc_q_o <= 1'b0;
  end
endmodule

// File: rtl/hbridge_pwm_seq.sv
module hbridge_pwm_seq
  import hbpwm_pkg::*;
#(
  parameter int CLK_KHZ  = 50000,
  parameter int DUTY_W   = 5,
  parameter int FAST_KHZ = 20,
  parameter int DEAD_NS  = 3000,
  parameter int MIN_PCT  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dir_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              freq_sel_i,
  input  logic              oc_i,
  input  logic              fault_i,
  input  logic              oc_clr_i,
  output logic              hs1_o,
  output logic              ls1_o,
  output logic              hs2_o,
  output logic              ls2_o,
  output logic              oc_latched_o
);
  localparam int STEPS     = 1 << DUTY_W;
  localparam int STEP_FAST = CLK_KHZ / (FAST_KHZ * STEPS);
  localparam int DEAD_CYC  = (CLK_KHZ * DEAD_NS) / 1000000;
  localparam int MIN_CODE  = (STEPS * MIN_PCT + 99) / 100 - 1;
  localparam int CNT_W     = $clog2(2 * STEPS * STEP_FAST + 1);

  logic             oc_q, kill, run, dir_run;
  logic [CNT_W-1:0] cnt, on_len, per_len;
  gates_t           gates;

  assign kill = fault_i | oc_i | oc_q | ~en_i;

  hbpwm_oc_latch u_oc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .oc_i   (oc_i),
    .clr_i  (oc_clr_i),
    .oc_q_o (oc_q)
  );

  hbpwm_timebase #(
    .DUTY_W    (DUTY_W),
    .STEP_FAST (STEP_FAST),
    .DEAD_CYC  (DEAD_CYC),
    .MIN_CODE  (MIN_CODE),
    .CNT_W     (CNT_W)
  ) u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kill_i     (kill),
    .dir_i      (dir_i),
    .duty_i     (duty_i),
    .freq_sel_i (freq_sel_i),
    .run_o      (run),
    .dir_o      (dir_run),
    .cnt_o      (cnt),
    .on_len_o   (on_len),
    .per_len_o  (per_len)
  );

  hbpwm_gate_map #(
    .CNT_W    (CNT_W),
    .DEAD_CYC (DEAD_CYC)
  ) u_map (
    .run_i     (run),
    .kill_i    (kill),
    .dir_i     (dir_run),
    .cnt_i     (cnt),
    .on_len_i  (on_len),
    .per_len_i (per_len),
    .gates_o   (gates)
  );

  assign hs1_o        = gates.hs1;
  assign ls1_o        = gates.ls1;
  assign hs2_o        = gates.hs2;
  assign ls2_o        = gates.ls2;
  assign oc_latched_o = oc_q;
endmodule

// File: rtl/hbpwm_seq_chk.sv
module hbpwm_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic oc_i,
  input logic fault_i,
  input logic oc_clr_i,
  input logic hs1_o,
  input logic ls1_o,
  input logic hs2_o,
  input logic ls2_o,
  input logic oc_latched_o
);
  logic any_on;
  assign any_on = hs1_o | ls1_o | hs2_o | ls2_o;

  a_r5_leg1_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs1_o && ls1_o));
  a_r5_leg2_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs2_o && ls2_o));
  a_r5_ls1_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls1_o) |-> !$past(hs1_o));
  a_r5_hs1_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs1_o) |-> !$past(ls1_o));
  a_r5_ls2_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls2_o) |-> !$past(hs2_o));
  a_r5_hs2_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs2_o) |-> !$past(ls2_o));
  a_r3_one_high_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs1_o && hs2_o));
  a_r8_oc_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_i || oc_latched_o) |-> !any_on);
  a_r10_fault_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |-> !any_on);
  a_r1_disabled_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !any_on);
  a_r8_oc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_i |=> oc_latched_o);
  a_r9_oc_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_latched_o && !oc_clr_i) |=> oc_latched_o);
endmodule

bind hbridge_pwm_seq hbpwm_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .oc_i         (oc_i),
  .fault_i      (fault_i),
  .oc_clr_i     (oc_clr_i),
  .hs1_o        (hs1_o),
  .ls1_o        (ls1_o),
  .hs2_o        (hs2_o),
  .ls2_o        (ls2_o),
  .oc_latched_o (oc_latched_o)
);

// File: tb/hbridge_pwm_seq_bench.sv
`timescale 1ns/1ps
module hbridge_pwm_seq_bench;
  localparam int CLK_KHZ = 1280;
  localparam int SF      = CLK_KHZ / (20 * 32);      // 2 cycles per step, fast rate
  localparam int D       = (CLK_KHZ * 3000) / 1000000; // 3 dead cycles

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, dir_i = 1'b0, freq_sel_i = 1'b0;
  logic oc_i = 1'b0, fault_i = 1'b0, oc_clr_i = 1'b0;
  logic [4:0] duty_i = '0;
  logic hs1_o, ls1_o, hs2_o, ls2_o, oc_latched_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hbridge_pwm_seq #(.CLK_KHZ(CLK_KHZ)) u_hbridge_pwm_seq (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .dir_i(dir_i), .duty_i(duty_i),
    .freq_sel_i(freq_sel_i), .oc_i(oc_i), .fault_i(fault_i), .oc_clr_i(oc_clr_i),
    .hs1_o(hs1_o), .ls1_o(ls1_o), .hs2_o(hs2_o), .ls2_o(ls2_o),
    .oc_latched_o(oc_latched_o)
  );

  function automatic logic [3:0] gates();
    return {hs1_o, ls1_o, hs2_o, ls2_o};
  endfunction

  // expected {hs1,ls1,hs2,ls2} at period position k
  function automatic logic [3:0] exp_g(bit d, int c, bit f, int k);
    int st = f ? 2 * SF : SF;
    int p  = 32 * st;
    int ce = (c < 3) ? 3 : c;
    int on = (ce + 1) * st;
    bit hi = (k < on);
    bit lo = (k >= on + D) && (k < p - D);
    return d ? {1'b0, 1'b1, hi, lo} : {hi, lo, 1'b0, 1'b1};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_off(string req);
    chk(gates() == 4'b0, req, 32'(gates()), 0);
  endtask

  // from idle: edge to gap, D all-off cycles, then cycle 0 of a period
  task automatic gap_check(string req);
    for (int i = 0; i < D; i++) begin
      chk_off(req);
      tick();
    end
  endtask

  task automatic gap_then_run(string req);
    tick();
    gap_check(req);
  endtask

  task automatic check_period(bit d, int c, bit f, string req,
                              int chg_k, bit nd, int nc, bit nf);
    int p = 32 * (f ? 2 * SF : SF);
    for (int k = 0; k < p; k++) begin
      chk(gates() == exp_g(d, c, f, k), req, 32'(gates()), 32'(exp_g(d, c, f, k)));
      if (k == chg_k) begin
        dir_i = nd; duty_i = 5'(nc); freq_sel_i = nf;
      end
      tick();
    end
  endtask

  task automatic run_one(bit d, int c, bit f);
    en_i = 1'b0;
    #1 chk_off("R1 disable");
    tick();
    dir_i = d; duty_i = 5'(c); freq_sel_i = f; en_i = 1'b1;
    gap_then_run("R2 start gap");
    check_period(d, c, f, "R3 R4 R5 pattern", -1, d, c, f);
    check_period(d, c, f, "R5 second period", -1, d, c, f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_off("R1 reset");
    chk(oc_latched_o == 1'b0, "R1 reset status", 32'(oc_latched_o), 0);
    rst_ni = 1'b1;
    tick();
    chk_off("R1 idle");

    // sweep: direction x rate x every duty code (covers clamp and 100 %)
    for (int d = 0; d < 2; d++)
      for (int f = 0; f < 2; f++)
        for (int c = 0; c < 32; c++)
          run_one(d[0], c, f[0]);

    // R6: duty and rate change mid period apply next period
    run_one(1'b0, 5, 1'b0);
    check_period(1'b0, 5, 1'b0, "R6 old values hold", 3, 1'b0, 20, 1'b1);
    check_period(1'b0, 20, 1'b1, "R6 new values", -1, 1'b0, 20, 1'b1);

    // R7: reversal at boundary with all-off gap
    check_period(1'b0, 20, 1'b1, "R7 before reversal", 4, 1'b1, 20, 1'b1);
    gap_check("R7 reversal gap");
    check_period(1'b1, 20, 1'b1, "R7 reversed", -1, 1'b1, 20, 1'b1);

    // R8 / R9: overcurrent shutdown, latch, clear
    run_one(1'b0, 31, 1'b0);
    oc_i = 1'b1;
    #1 chk_off("R8 oc same cycle");
    tick();
    chk(oc_latched_o == 1'b1, "R8 status set", 32'(oc_latched_o), 1);
    oc_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(oc_latched_o == 1'b1, "R9 status held", 32'(oc_latched_o), 1);
      chk_off("R9 gates held off");
    end
    oc_i = 1'b1; oc_clr_i = 1'b1;
    tick();
    chk(oc_latched_o == 1'b1, "R9 set beats clear", 32'(oc_latched_o), 1);
    oc_i = 1'b0;
    tick();
    chk(oc_latched_o == 1'b0, "R9 cleared", 32'(oc_latched_o), 0);
    chk_off("R9 idle after clear");
    oc_clr_i = 1'b0;
    gap_then_run("R9 restart gap");
    check_period(1'b0, 31, 1'b0, "R9 restart", -1, 1'b0, 31, 1'b0);

    // R10: fault shutdown and restart
    tick(); tick();
    fault_i = 1'b1;
    #1 chk_off("R10 fault same cycle");
    tick();
    chk_off("R10 fault held");
    chk(oc_latched_o == 1'b0, "R10 no oc status", 32'(oc_latched_o), 0);
    fault_i = 1'b0;
    gap_then_run("R10 restart gap");
    check_period(1'b0, 31, 1'b0, "R10 restart", -1, 1'b0, 31, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule